// File: doc/BRIEF.md
# Dequantizing 8x8 Inverse DCT Engine

This engine turns one 8x8 block of quantized transform coefficients back into 64 unsigned 8-bit picture samples. Software or an upstream decoder loads the signed 16-bit coefficients and a matching table of 16-bit quantization multipliers through a single write port. A start pulse then runs the transform. The engine dequantizes each coefficient, runs an integer column pass, then a row pass, through one shared 8-point butterfly, and streams the samples out over a ready/valid link.

The arithmetic is fixed-point with 13-bit constants. The column pass keeps two extra fractional bits for the row pass. Any column whose seven non-DC dequantized terms are zero skips the butterfly: it is filled with its scaled DC value. Final values are clamped to the signed 8-bit range and level-shifted by 128. While a block is in flight the engine reports busy and ignores both the load port and further start pulses.

Top module: `dqidct8_engine`

## Requirements
- R1: A write with `wr_tab`=0 stores `wr_data` as a coefficient and with `wr_tab`=1 as a multiplier, at index `wr_addr` = 8*row + column, where the row is the vertical frequency. Writes are taken only while `busy` is low.
- R2: Each coefficient is dequantized as the low 16 bits of the signed product of the coefficient and its multiplier.
- R3: The column pass computes an 8-point integer IDCT with 13-bit constants on each column. The pre-sums in0+in4, in0-in4, in7+in3 and in5+in1 wrap at 16 bits, and all accumulation wraps at 32 bits. Each result has 2^10 added, is shifted right arithmetically by 11, and is saturated to signed 16 bits.
- R4: When dequantized rows 1 to 7 of a column are all zero, all eight column-pass results of that column equal the dequantized DC shifted left by 2 and truncated to 16 bits, with no saturation. Bypassed and computed columns may mix in one block.
- R5: The row pass applies the same IDCT to each row of column-pass results with 2^17 added and an arithmetic shift of 18. Each result is clamped to [-128,127] and then increased by 128.
- R6: Exactly 64 samples are sent per start, row 0 first and column 0 first within a row. `out_last` is high with the 64th sample only.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold and the engine does not advance.
- R8: `busy` rises in the cycle after a start is sampled with `busy` low. It stays high until the last sample is accepted and is low in the next cycle. A start pulse while `busy` is high is ignored.
- R9: After reset, `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load strobe |
| wr_tab | input | 1 | 0 selects the coefficient store, 1 the multiplier store |
| wr_addr | input | 6 | Index 8*row + column |
| wr_data | input | 16 | Value to store |
| start | input | 1 | Begin transforming the loaded block |
| busy | output | 1 | Block in flight; loads and start are ignored |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_data | output | 8 | Unsigned sample |
| out_last | output | 1 | Marks the 64th sample of the block |

## Verification
The hardest case to reach is a column that takes the bypass while its result differs from what the butterfly would give. This needs a dequantized DC large enough that shifting it left by 2 wraps in 16 bits, where the butterfly would saturate instead. A related case is a raw AC coefficient that is non-zero but dequantizes to zero. The stimulus builds both cases on purpose: a DC of 10000 with unit multiplier, and a row-1 coefficient of 256 times a multiplier of 256. Blocks that mix bypassed and computed columns are also loaded. Random full-range blocks then drive the 16-bit pre-sum wraps and the 32-bit accumulator wraps, and the consumer's random stalls exercise the hold behaviour.

// File: rtl/dqidct8_pkg.sv
// Shared widths, types, fixed-point constants and arithmetic helpers for the
// dequantizing 8x8 inverse DCT. Assumes 16-bit coefficients and a 32-bit
// accumulator that wraps like two's-complement hardware.
package dqidct8_pkg;

    localparam int PTS       = 8;                 // points per 1-D transform
    localparam int IDX_W     = $clog2(PTS);
    localparam int ADDR_W    = 2 * IDX_W;
    localparam int COEF_W    = 16;
    localparam int ACC_W     = 32;
    localparam int SAMP_W    = 8;
    localparam int FRAC_BITS = 13;                // constant precision

    typedef logic signed [COEF_W-1:0] word_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef word_t [PTS-1:0]          wvec_t;

    // Merged even-part weights
    localparam word_t KE_P   = 16'sd10703;
    localparam word_t KE_Q   = 16'sd4433;
    localparam word_t KE_R   = -16'sd10704;
    // Merged odd-part rotation weights
    localparam word_t KR_A   = -16'sd6436;
    localparam word_t KR_B   = 16'sd9633;
    localparam word_t KR_C   = 16'sd6437;
    // Merged odd-part tap weights
    localparam word_t KO_A   = -16'sd4927;
    localparam word_t KO_B   = -16'sd7373;
    localparam word_t KO_C   = -16'sd4176;
    localparam word_t KO_D   = -16'sd20995;
    localparam word_t KO_E   = 16'sd4926;
    localparam word_t KO_F   = 16'sd4177;

    localparam acc_t SAT_HI = acc_t'(2 ** (COEF_W - 1) - 1);
    localparam acc_t SAT_LO = -acc_t'(2 ** (COEF_W - 1));

    // Sign-extend a 16-bit word to the accumulator width
    function automatic acc_t sx(input word_t v);
        return acc_t'(v);
    endfunction

    // Two-tap multiply-accumulate, wrapping at the accumulator width
    function automatic acc_t mac2(input word_t a, input word_t ka,
                                  input word_t b, input word_t kb);
        return sx(a) * sx(ka) + sx(b) * sx(kb);
    endfunction

    // Round-half-up, arithmetic shift, saturate to 16 bits
    function automatic word_t descale_sat(input acc_t v, input int unsigned sh);
        acc_t r;
        r = (v + (acc_t'(1) <<< (sh - 1))) >>> sh;
        if (r > SAT_HI) return word_t'(SAT_HI);
        if (r < SAT_LO) return word_t'(SAT_LO);
        return word_t'(r);
    endfunction

endpackage

// File: rtl/dqidct8_dequant.sv
// Dequantizer for one column: multiplies each coefficient by its multiplier
// and keeps the low 16 bits (R2). Also flags a column whose non-DC terms are
// all zero after dequantization, which selects the bypass (R4).
// Assumes a purely combinational path; the caller registers the results.
module dqidct8_dequant
    import dqidct8_pkg::*;
(
    input  wvec_t coef,
    input  wvec_t quant,
    output wvec_t deq,
    output logic  ac_zero
);

    // One truncating multiplier per point
    for (genvar i = 0; i < PTS; i++) begin : g_mul
        assign deq[i] = coef[i] * quant[i];
    end

    // Bypass qualifier: rows 1..PTS-1 all zero
    assign ac_zero = (deq[PTS-1:1] == '0);

endmodule

// File: rtl/dqidct8_butterfly.sv
// Shared 8-point integer inverse DCT. A select input picks the column-pass or
// row-pass descale. Pre-sums wrap at 16 bits and products and sums wrap at
// 32 bits (R3, R5). Assumes inputs are stable for the cycle they are used.
module dqidct8_butterfly
    import dqidct8_pkg::*;
#(
    parameter int SH_COL = 11,
    parameter int SH_ROW = 18
) (
    input  logic  row_pass,
    input  wvec_t x_in,
    output wvec_t y_out
);

    word_t x [PTS];
    word_t s04, d04, z3, z4;
    acc_t  e0, e1, t2, t3, zz3, zz4;
    acc_t  ev [PTS/2];
    acc_t  od [PTS/2];

    // Unpack the input lanes
    always_comb begin
        for (int i = 0; i < PTS; i++) x[i] = x_in[i];
    end

    // Even and odd halves of the flowgraph
    always_comb begin
        s04 = x[0] + x[4];
        d04 = x[0] - x[4];
        e0  = sx(s04) <<< FRAC_BITS;
        e1  = sx(d04) <<< FRAC_BITS;
        t3  = mac2(x[2], KE_P, x[6], KE_Q);
        t2  = mac2(x[2], KE_Q, x[6], KE_R);
        ev[0] = e0 + t3;
        ev[1] = e1 + t2;
        ev[2] = e1 - t2;
        ev[3] = e0 - t3;

        z3  = x[7] + x[3];
        z4  = x[5] + x[1];
        zz3 = mac2(z3, KR_A, z4, KR_B);
        zz4 = mac2(z4, KR_C, z3, KR_B);
        od[3] = mac2(x[7], KO_A, x[1], KO_B) + zz3;
        od[2] = mac2(x[5], KO_C, x[3], KO_D) + zz4;
        od[0] = mac2(x[7], KO_B, x[1], KO_E) + zz4;
        od[1] = mac2(x[5], KO_D, x[3], KO_F) + zz3;
    end

    // Mirrored output pairs with pass-dependent descale
    for (genvar p = 0; p < PTS/2; p++) begin : g_out
        assign y_out[p] = row_pass ? descale_sat(ev[p] + od[p], SH_ROW)
                                   : descale_sat(ev[p] + od[p], SH_COL);
        assign y_out[PTS-1-p] = row_pass ? descale_sat(ev[p] - od[p], SH_ROW)
                                         : descale_sat(ev[p] - od[p], SH_COL);
    end

endmodule

// File: rtl/dqidct8_pixfmt.sv
// Output formatter: clamps each row-pass word to the signed sample range and
// level-shifts it to unsigned (R5). Combinational and one lane per point.
module dqidct8_pixfmt
    import dqidct8_pkg::*;
(
    input  wvec_t                         v,
    output logic [PTS-1:0][SAMP_W-1:0]   pix
);

    localparam word_t S_HI = word_t'(2 ** (SAMP_W - 1) - 1);
    localparam word_t S_LO = -word_t'(2 ** (SAMP_W - 1));

    for (genvar i = 0; i < PTS; i++) begin : g_lane
        word_t w, c;
        // Clamp then flip the sign bit (adds half the range)
        always_comb begin
            w = v[i];
            if (w > S_HI)      c = S_HI;
            else if (w < S_LO) c = S_LO;
            else               c = w;
            pix[i] = c[SAMP_W-1:0] ^ {1'b1, {(SAMP_W-1){1'b0}}};
        end
    end

endmodule

// File: rtl/dqidct8_engine.sv
// Dequantizing 8x8 inverse DCT engine. It loads coefficients and multipliers
// through a write port and runs one column per cycle through the shared
// butterfly into a workspace. It then computes one row at a time and streams
// that row's eight samples over ready/valid. Assumes the block is fully loaded
// before start; the stores are not cleared by reset.
module dqidct8_engine
    import dqidct8_pkg::*;
#(
    parameter int P1_SHIFT  = 11,
    parameter int P2_SHIFT  = 18,
    parameter int PRE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_tab,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              start,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SAMP_W-1:0] out_data,
    output logic              out_last
);

    localparam int                 NWORDS = PTS * PTS;
    localparam logic [IDX_W-1:0]   IDX_END = IDX_W'(PTS - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_COLS, ST_ROWS, ST_EMIT} state_t;

    state_t             state;
    logic [IDX_W-1:0]   idx;      // column in ST_COLS, row otherwise
    logic [IDX_W-1:0]   k;        // sample within the emitted row

    word_t coef_mem  [NWORDS];
    word_t quant_mem [NWORDS];
    word_t ws_mem    [NWORDS];
    logic [PTS-1:0][SAMP_W-1:0] obuf;

    wvec_t col_coef, col_quant, col_deq, row_ws, bf_in, bf_out;
    logic  col_ac_zero;
    word_t dc_scaled;
    logic [PTS-1:0][SAMP_W-1:0] pix;

    // Gather the current column from the stores and the current row from the workspace
    always_comb begin
        for (int j = 0; j < PTS; j++) begin
            col_coef[j]  = coef_mem[{IDX_W'(j), idx}];
            col_quant[j] = quant_mem[{IDX_W'(j), idx}];
            row_ws[j]    = ws_mem[{idx, IDX_W'(j)}];
        end
    end

    dqidct8_dequant u_deq (
        .coef    (col_coef),
        .quant   (col_quant),
        .deq     (col_deq),
        .ac_zero (col_ac_zero)
    );

    assign bf_in = (state == ST_ROWS) ? row_ws : col_deq;

    dqidct8_butterfly #(
        .SH_COL (P1_SHIFT),
        .SH_ROW (P2_SHIFT)
    ) u_bfly (
        .row_pass (state == ST_ROWS),
        .x_in     (bf_in),
        .y_out    (bf_out)
    );

    dqidct8_pixfmt u_fmt (
        .v   (bf_out),
        .pix (pix)
    );

    // Bypass value: DC with extra fractional bits, wrapping at 16 bits (R4)
    assign dc_scaled = col_deq[0] <<< PRE_SHIFT;

    // Load port, accepted only while idle (R1, R8)
    always_ff @(posedge clk) begin
        if (wr_en && state == ST_IDLE) begin
            if (wr_tab) quant_mem[wr_addr] <= wr_data;
            else        coef_mem[wr_addr]  <= wr_data;
        end
    end

    // Column pass writes one workspace column per cycle (R3, R4)
    always_ff @(posedge clk) begin
        if (state == ST_COLS) begin
            for (int j = 0; j < PTS; j++)
                ws_mem[{IDX_W'(j), idx}] <= col_ac_zero ? dc_scaled : bf_out[j];
        end
    end

    // Row pass captures one formatted row of samples (R5)
    always_ff @(posedge clk) begin
        if (state == ST_ROWS) obuf <= pix;
    end

    // Sequencer: columns, then rows interleaved with output bursts (R6, R7, R8, R9)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            k     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_COLS;
                    idx   <= '0;
                end
                ST_COLS: begin
                    if (idx == IDX_END) begin
                        state <= ST_ROWS;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_ROWS: begin
                    state <= ST_EMIT;
                    k     <= '0;
                end
                ST_EMIT: if (out_ready) begin
                    k <= k + 1'b1;
                    if (k == IDX_END) begin
                        if (idx == IDX_END) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            state <= ST_ROWS;
                            idx   <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign out_valid = (state == ST_EMIT);
    assign out_data  = obuf[k];
    assign out_last  = out_valid && (idx == IDX_END) && (k == IDX_END);

endmodule

// File: rtl/dqidct8_engine_chk.sv
// Protocol checker for the engine's ports, attached by bind. It counts
// accepted samples so that the block framing can be checked.
module dqidct8_engine_chk
    import dqidct8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SAMP_W-1:0] out_data,
    input logic              out_last
);

    localparam int CNT_W = $clog2(PTS * PTS) + 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PTS * PTS - 1);

    logic [CNT_W-1:0] hs_cnt;

    // Count accepted samples within the current block
    always_ff @(posedge clk) begin
        if (!rst_n)                              hs_cnt <= '0;
        else if (out_valid && out_ready)         hs_cnt <= out_last ? '0 : hs_cnt + 1'b1;
    end

    assert_last_has_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_last_on_64th_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (out_last == (hs_cnt == LAST_IDX)));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_start_raises_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_valid_within_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    assert_release_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !busy);

endmodule

bind dqidct8_engine dqidct8_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/dqidct8_engine_tb_top.sv
// Scoreboard bench: the driver loads a block and pushes the model's 64
// expected samples; the monitor pops and compares each accepted sample.
module dqidct8_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_tab = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;

    int          checks = 0;
    int          fails = 0;
    bit          stall_en = 1'b0;
    string       cur_tag = "";
    logic [8:0]  exp_q[$];
    int          cf[64];
    int          qt[64];
    int          sample_no = 0;

    always #2 clk = ~clk;   // 250 MHz

    dqidct8_engine dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tab(wr_tab),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .busy(busy),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int w16(input int v);
        return int'(shortint'(v));
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int rnd_shift(input int v, input int sh);
        int r;
        r = (v + (1 << (sh - 1))) >>> sh;
        return clampi(r, -32768, 32767);
    endfunction

    // Classic rotation form; identical modulo 2^32 to the merged-weight form
    task automatic ref_1d(input int a[8], input int sh, output int o[8]);
        int z1, z2, z3, z4, z5, p0, p1, p2, p3, q0, q1, q2, q3;
        int h10, h11, h12, h13;
        z2 = a[2]; z3 = a[6];
        z1 = (z2 + z3) * 4433;
        p2 = z1 + z3 * (-15137);
        p3 = z1 + z2 * 6270;
        p0 = w16(a[0] + a[4]) * 8192;
        p1 = w16(a[0] - a[4]) * 8192;
        h10 = p0 + p3; h13 = p0 - p3; h11 = p1 + p2; h12 = p1 - p2;
        q0 = a[7]; q1 = a[5]; q2 = a[3]; q3 = a[1];
        z1 = q0 + q3; z2 = q1 + q2;
        z3 = w16(q0 + q2); z4 = w16(q1 + q3);
        z5 = (z3 + z4) * 9633;
        q0 = q0 * 2446; q1 = q1 * 16819; q2 = q2 * 25172; q3 = q3 * 12299;
        z1 = z1 * (-7373); z2 = z2 * (-20995);
        z3 = z3 * (-16069) + z5; z4 = z4 * (-3196) + z5;
        q0 += z1 + z3; q1 += z2 + z4; q2 += z2 + z3; q3 += z1 + z4;
        o[0] = rnd_shift(h10 + q3, sh); o[7] = rnd_shift(h10 - q3, sh);
        o[1] = rnd_shift(h11 + q2, sh); o[6] = rnd_shift(h11 - q2, sh);
        o[2] = rnd_shift(h12 + q1, sh); o[5] = rnd_shift(h12 - q1, sh);
        o[3] = rnd_shift(h13 + q0, sh); o[4] = rnd_shift(h13 - q0, sh);
    endtask

    task automatic push_expected();
        int deq[64];
        int ws[64];
        int a[8];
        int o[8];
        bit zac;
        for (int i = 0; i < 64; i++) deq[i] = w16(cf[i] * qt[i]);
        for (int c = 0; c < 8; c++) begin
            zac = 1'b1;
            for (int r = 1; r < 8; r++) if (deq[r*8+c] != 0) zac = 1'b0;
            for (int r = 0; r < 8; r++) a[r] = deq[r*8+c];
            ref_1d(a, 11, o);
            for (int r = 0; r < 8; r++) ws[r*8+c] = zac ? w16(deq[c] * 4) : o[r];
        end
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) a[c] = ws[r*8+c];
            ref_1d(a, 18, o);
            for (int c = 0; c < 8; c++)
                exp_q.push_back({(r == 7 && c == 7), 8'(clampi(o[c], -128, 127) + 128)});
        end
    endtask

    // ---------------- driver ----------------
    task automatic load_block();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_tab = t[0]; wr_addr = 6'(i);
                wr_data = 16'(t == 0 ? cf[i] : qt[i]);
            end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0 || busy) @(negedge clk);
    endtask

    task automatic run_block(input string tag);
        cur_tag = tag;
        sample_no = 0;
        load_block();
        push_expected();
        fire();
        wait_done();
    endtask

    task automatic clear_block();
        for (int i = 0; i < 64; i++) begin cf[i] = 0; qt[i] = 1; end
    endtask

    // ---------------- monitor ----------------
    bit         held = 1'b0;
    logic [7:0] held_data;
    logic [8:0] item;

    always @(negedge clk) begin
        if (!rst_n) begin
            out_ready = 1'b0;
            held = 1'b0;
        end else begin
            if (held)
                chk(out_valid === 1'b1 && out_data === held_data,
                    "R7 output held during stall", int'(out_data), int'(held_data));
            out_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 sample without pending block", int'(out_data), -1);
                end else begin
                    item = exp_q.pop_front();
                    if ({out_last, out_data} !== item)
                        $display("FAIL %s sample %0d (last,data)", cur_tag, sample_no);
                    chk({out_last, out_data} === item, {cur_tag, " sample"},
                        int'({out_last, out_data}), int'(item));
                    sample_no++;
                end
            end
            held = out_valid && !out_ready;
            held_data = out_data;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R9 busy low in reset", int'(busy), 0);
        chk(out_valid === 1'b0, "R9 out_valid low in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && out_valid === 1'b0, "R9 idle after reset",
            int'({busy, out_valid}), 0);

        // All zero: every sample is mid-scale
        clear_block();
        run_block("R5 all-zero");

        // DC only, moderate
        clear_block(); cf[0] = 50; qt[0] = 16;
        run_block("R4 R5 dc-only");

        // DC whose bypass shift wraps at 16 bits (butterfly would saturate)
        clear_block(); cf[0] = 10000;
        run_block("R4 dc wrap bypass");

        // Non-zero raw AC that dequantizes to zero still bypasses
        clear_block(); cf[0] = 10000; cf[8] = 256; qt[8] = 256;
        run_block("R2 R4 zero after dequant");

        // Large positive DC saturates the sample high
        clear_block(); cf[0] = 2000;
        run_block("R5 high clamp");

        // Single AC terms at transposed positions tell the index order apart
        clear_block(); cf[3] = 40; qt[3] = 8;
        run_block("R1 R6 addr row0 col3");
        clear_block(); cf[24] = 40; qt[24] = 8;
        run_block("R1 R6 addr row3 col0");

        // Mixed bypassed and computed columns
        clear_block();
        for (int i = 0; i < 64; i++) begin
            qt[i] = $urandom_range(1, 12);
            if ((i % 8) % 2 == 0 || i < 8) cf[i] = int'($urandom_range(0, 200)) - 100;
        end
        run_block("R3 R4 mixed columns");

        // Realistic range under random back-pressure
        stall_en = 1'b1;
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 64; i++) begin
                cf[i] = int'($urandom_range(0, 127)) - 64;
                qt[i] = $urandom_range(1, 16);
            end
            run_block("R2 R3 R5 R7 small random stalled");
        end

        // Full-range random: 16-bit product, pre-sum and accumulator wraps
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 64; i++) begin
                cf[i] = w16(int'($urandom));
                qt[i] = int'($urandom_range(0, 65535));
            end
            run_block("R2 R3 R5 full range");
        end
        stall_en = 1'b0;

        // Loads while busy are ignored, both for this block and the next
        for (int i = 0; i < 64; i++) begin
            cf[i] = int'($urandom_range(0, 255)) - 128;
            qt[i] = $urandom_range(1, 8);
        end
        cur_tag = "R1 R8 writes while busy";
        sample_no = 0;
        load_block();
        push_expected();
        fire();
        chk(busy === 1'b1, "R8 busy after start", int'(busy), 1);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_tab = j[0]; wr_addr = 6'(j); wr_data = 16'h7abc;
        end
        @(negedge clk); wr_en = 1'b0;
        wait_done();
        @(negedge clk);
        chk(busy === 1'b0, "R8 busy low after last sample", int'(busy), 0);

        // Re-run without reload; extra starts while busy are ignored
        cur_tag = "R8 rerun and start ignored";
        sample_no = 0;
        push_expected();
        fire();
        while (!out_valid) @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk); start = 1'b1;
        end
        @(negedge clk); start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(busy === 1'b0 && out_valid === 1'b0, "R8 no extra block from start while busy",
            int'({busy, out_valid}), 0);
        chk(exp_q.size() == 0, "R6 all expected samples delivered", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule